// File: doc/BRIEF.md
# Processor Activity Watchdog with Startup Delay

This block checks that a processor keeps toggling a strobe line. Once the system reset is released, it waits a start-up delay chosen by a 2-bit code and then begins monitoring. From then on, every qualified level change on the strobe restarts an interval counter. If the interval counter reaches the timeout chosen by a second 2-bit code, the block drives its active-low alarm output low for a fixed number of ticks. The next interval is timed from the first cycle of that low pulse.

Durations are counted in ticks of an external time-base strobe. The exception is the enable setup window, which is counted in clock cycles. A strobe level counts only after it has passed a two-flop synchronizer and then stayed stable for a minimum number of clock cycles. An active-high enable switches monitoring on and off. When the enable rises, monitoring starts after the setup window has passed.

The controller has six states:
- WAIT_REL: waits for system reset to be released.
- STARTUP: counts the start-up delay.
- DISABLED: the enable is low.
- SETUP: the window after the enable rises.
- MONITOR: times the interval between strobes.
- PULSE: the alarm output is low.

The state changes are:
- Any state goes to WAIT_REL while system reset is active.
- WAIT_REL goes to STARTUP when system reset is released.
- STARTUP goes to MONITOR when the delay ends with the enable high, or to DISABLED when it ends with the enable low.
- DISABLED goes to SETUP when the enable is high.
- SETUP goes to MONITOR when the window ends, or back to DISABLED if the enable drops.
- MONITOR goes to PULSE when the timeout is reached.
- PULSE goes to MONITOR when the pulse width has elapsed.
- MONITOR and PULSE both go to DISABLED when the enable drops.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wdo_n` is high (deasserted).
- R2: A high `sys_rst_act` forces `wdo_n` high by the next clock edge and holds it high for as long as it stays high. Releasing it restarts the start-up delay.
- R3: After `sys_rst_act` falls, monitoring begins once `START_T0..START_T3` ticks have passed, selected by `start_sel` (0, 1, 2 or 3). No alarm can occur before the start-up delay plus the timeout.
- R4: In MONITOR, if no qualified edge arrives within `TMO_T0..TMO_T3` ticks (selected by `tmo_sel` 0 to 3), `wdo_n` goes low.
- R5: In MONITOR, a qualified edge in either direction clears the interval counter. Strobing faster than the timeout keeps `wdo_n` high.
- R6: A new synchronized `wdi` level counts as an edge only after it has been held for `MINW_CYC` clock cycles. Shorter glitches do not restart the interval.
- R7: Each alarm pulse holds `wdo_n` low for exactly `PULSE_T` ticks.
- R8: The next interval starts in the cycle the pulse begins. Without strobes, pulses start every timeout period.
- R9: Edges on `wdi` while `wdo_n` is low are ignored.
- R10: While `wd_en` is low, no alarm is produced and `wdi` is ignored.
- R11: If `wd_en` is low when the start-up delay ends, monitoring waits. When `wd_en` later goes high, monitoring begins after `SETUP_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| tick | input | 1 | One-cycle time-base strobe |
| sys_rst_act | input | 1 | System reset currently active (high) |
| wd_en | input | 1 | Watchdog enable, active high |
| wdi | input | 1 | Strobe input from the processor |
| start_sel | input | 2 | Start-up delay code |
| tmo_sel | input | 2 | Timeout code |
| wdo_n | output | 1 | Alarm output, active low |

## Verification
A wrong state or a wrong count shows up only as the timing of `wdo_n` edges, so the bench measures the first low, the pulse width and the pulse period in clock cycles. The tolerance is set by the tick alignment. A counter that fails to clear on a strobe shows up within one timeout period as an alarm that should not be there. A stuck DISABLED or SETUP state shows up as a missing alarm about one timeout after the enable rises. A wrongly qualified glitch moves the alarm later by the glitch offset, which is well outside the window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_REL,
        ST_STARTUP,
        ST_DISABLED,
        ST_SETUP,
        ST_MONITOR,
        ST_PULSE
    } wdt_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/wdt_input_qual.sv
module wdt_input_qual #(
    parameter int unsigned MINW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi,
    output logic qual_edge
);
    localparam int unsigned QW = $clog2(MINW_CYC + 1);

    logic          s1, s2, held_lvl;
    logic [QW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1        <= 1'b0;
            s2        <= 1'b0;
            held_lvl  <= 1'b0;
            run_cnt   <= '0;
            qual_edge <= 1'b0;
        end else begin
            s1        <= wdi;
            s2        <= s1;
            qual_edge <= 1'b0;
            if (s2 == held_lvl) begin
                run_cnt <= '0;
            end else if (run_cnt == QW'(MINW_CYC - 1)) begin
                held_lvl  <= s2;
                run_cnt   <= '0;
                qual_edge <= 1'b1;
            end else begin
                run_cnt <= run_cnt + QW'(1);
            end
        end
    end

    // R6
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qual_edge |=> !qual_edge);
endmodule

// File: rtl/wdt_limit_sel.sv
module wdt_limit_sel #(
    parameter int unsigned W  = 8,
    parameter int unsigned V0 = 1,
    parameter int unsigned V1 = 2,
    parameter int unsigned V2 = 3,
    parameter int unsigned V3 = 4
) (
    input  logic [1:0]   sel,
    output logic [W-1:0] lim
);
    always_comb begin
        unique case (sel)
            2'd0:    lim = W'(V0);
            2'd1:    lim = W'(V1);
            2'd2:    lim = W'(V2);
            default: lim = W'(V3);
        endcase
    end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int unsigned START_T0  = 200,
    parameter int unsigned START_T1  = 8000,
    parameter int unsigned START_T2  = 32000,
    parameter int unsigned START_T3  = 128000,
    parameter int unsigned TMO_T0    = 2000,
    parameter int unsigned TMO_T1    = 8000,
    parameter int unsigned TMO_T2    = 32000,
    parameter int unsigned TMO_T3    = 128000,
    parameter int unsigned PULSE_T   = 200,
    parameter int unsigned SETUP_CYC = 300,
    parameter int unsigned MINW_CYC  = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sys_rst_act,
    input  logic       wd_en,
    input  logic       wdi,
    input  logic [1:0] start_sel,
    input  logic [1:0] tmo_sel,
    output logic       wdo_n
);
    localparam int unsigned MAXS = max2(max2(START_T0, START_T1), max2(START_T2, START_T3));
    localparam int unsigned MAXT = max2(max2(TMO_T0, TMO_T1), max2(TMO_T2, TMO_T3));
    localparam int unsigned CW   = $clog2(max2(max2(MAXS, MAXT), SETUP_CYC) + 1);
    localparam int unsigned PW   = $clog2(PULSE_T + 1);

    wdt_state_e    state, state_d;
    logic [CW-1:0] cnt, cnt_d, start_lim, tmo_lim;
    logic [PW-1:0] pcnt, pcnt_d;
    logic          qual_edge;

    wdt_input_qual #(.MINW_CYC(MINW_CYC)) u_qual (
        .clk(clk), .rst_n(rst_n), .wdi(wdi), .qual_edge(qual_edge)
    );

    wdt_limit_sel #(.W(CW), .V0(START_T0), .V1(START_T1), .V2(START_T2), .V3(START_T3))
        u_start_lim (.sel(start_sel), .lim(start_lim));

    wdt_limit_sel #(.W(CW), .V0(TMO_T0), .V1(TMO_T1), .V2(TMO_T2), .V3(TMO_T3))
        u_tmo_lim (.sel(tmo_sel), .lim(tmo_lim));

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        pcnt_d  = pcnt;
        if (sys_rst_act) begin
            state_d = ST_WAIT_REL;
            cnt_d   = '0;
            pcnt_d  = '0;
        end else begin
            unique case (state)
                ST_WAIT_REL: begin
                    state_d = ST_STARTUP;
                    cnt_d   = '0;
                end
                ST_STARTUP: if (tick) begin
                    if (cnt == start_lim - CW'(1)) begin
                        cnt_d   = '0;
                        state_d = wd_en ? ST_MONITOR : ST_DISABLED;
                    end else begin
                        cnt_d = cnt + CW'(1);
                    end
                end
                ST_DISABLED: begin
                    cnt_d = '0;
                    if (wd_en) state_d = ST_SETUP;
                end
                ST_SETUP: begin
                    if (!wd_en) begin
                        state_d = ST_DISABLED;
                    end else if (cnt == CW'(SETUP_CYC - 1)) begin
                        state_d = ST_MONITOR;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt + CW'(1);
                    end
                end
                ST_MONITOR: begin
                    if (!wd_en) begin
                        state_d = ST_DISABLED;
                    end else if (qual_edge) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt == tmo_lim - CW'(1)) begin
                            state_d = ST_PULSE;
                            cnt_d   = '0;
                            pcnt_d  = '0;
                        end else begin
                            cnt_d = cnt + CW'(1);
                        end
                    end
                end
                ST_PULSE: begin
                    if (!wd_en) begin
                        state_d = ST_DISABLED;
                        pcnt_d  = '0;
                    end else if (tick) begin
                        cnt_d = cnt + CW'(1);
                        if (pcnt == PW'(PULSE_T - 1)) begin
                            state_d = ST_MONITOR;
                            pcnt_d  = '0;
                        end else begin
                            pcnt_d = pcnt + PW'(1);
                        end
                    end
                end
                default: state_d = ST_WAIT_REL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_REL;
            cnt   <= '0;
            pcnt  <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            pcnt  <= pcnt_d;
        end
    end

    always_comb begin
        wdo_n = (state != ST_PULSE);
    end

    // R2
    sysrst_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |=> wdo_n);
    // R4
    pulse_from_monitor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> $past(state) == ST_MONITOR);
    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> (pcnt < PW'(PULSE_T)));
    // R10
    disabled_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && !sys_rst_act) |=> wdo_n);
endmodule

// File: tb/wdt_supervisor_test.sv
module wdt_supervisor_test;
    localparam int TPER = 4;   // clocks per tick
    localparam int ST0 = 4, ST1 = 6, ST2 = 8, ST3 = 10;
    localparam int TM0 = 10, TM1 = 14, TM2 = 18, TM3 = 22;
    localparam int PT = 3, SETC = 5, MINW = 4;

    logic clk = 0, rst_n = 0, tick = 0, sys_rst_act = 1, wd_en = 1, wdi = 0;
    logic [1:0] start_sel = 0, tmo_sel = 0;
    logic wdo_n;
    int   tcnt = 0;
    int   errors = 0, checks = 0;

    always #2 clk = ~clk;
    always @(posedge clk) begin
        tcnt <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
        tick <= (tcnt == TPER - 2);
    end

    wdt_supervisor #(
        .START_T0(ST0), .START_T1(ST1), .START_T2(ST2), .START_T3(ST3),
        .TMO_T0(TM0), .TMO_T1(TM1), .TMO_T2(TM2), .TMO_T3(TM3),
        .PULSE_T(PT), .SETUP_CYC(SETC), .MINW_CYC(MINW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sys_rst_act(sys_rst_act),
        .wd_en(wd_en), .wdi(wdi), .start_sel(start_sel), .tmo_sel(tmo_sel),
        .wdo_n(wdo_n)
    );

    // {start_sel, tmo_sel, expected clocks to first low}
    localparam int NV = 4;
    localparam int VEC [NV][3] = '{
        '{0, 0, (ST0 + TM0) * TPER},
        '{1, 2, (ST1 + TM2) * TPER},
        '{3, 1, (ST3 + TM1) * TPER},
        '{2, 3, (ST2 + TM3) * TPER}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input int n, output int first);
        first = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!wdo_n && first < 0) first = i + 1;
        end
    endtask

    task automatic sys_restart(input logic [1:0] s, input logic [1:0] t, input logic en);
        sys_rst_act = 1; start_sel = s; tmo_sel = t; wd_en = en;
        clks(5);
        sys_rst_act = 0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int f, w, p;
        clks(3);
        check(wdo_n === 1'b1, "R1 in reset", wdo_n, 1);
        rst_n = 1;
        clks(3);
        check(wdo_n === 1'b1, "R1 after reset", wdo_n, 1);

        // R3 R4: startup and timeout codes
        for (int v = 0; v < NV; v++) begin
            sys_restart(2'(VEC[v][0]), 2'(VEC[v][1]), 1'b1);
            watch(200, f);
            check(f >= VEC[v][2] - 5 && f <= VEC[v][2] + 5, "R3/R4 first alarm", f, VEC[v][2]);
        end

        // R7 R8 R9: pulse width, period, edges ignored in pulse
        sys_restart(0, 0, 1'b1);
        while (wdo_n) @(negedge clk);
        w = 0;
        while (!wdo_n) begin w++; @(negedge clk); end
        check(w == PT * TPER, "R7 pulse width", w, PT * TPER);
        p = w;
        while (wdo_n) begin p++; @(negedge clk); end
        check(p == TM0 * TPER, "R8 pulse period", p, TM0 * TPER);
        clks(2);
        wdi = ~wdi;  // R9: toggle during pulse
        p = 2;
        while (!wdo_n) begin p++; @(negedge clk); end
        while (wdo_n) begin p++; @(negedge clk); end
        check(p >= TM0 * TPER - 1 && p <= TM0 * TPER + 1, "R9 ignored in pulse", p, TM0 * TPER);

        // R2: system reset during pulse
        sys_rst_act = 1;
        clks(1);
        check(wdo_n === 1'b1, "R2 forced high", wdo_n, 1);
        watch(100, f);
        check(f == -1, "R2 held high", f, -1);

        // R5: regular strobing
        sys_restart(0, 0, 1'b1);
        clks(20);
        f = -1;
        for (int k = 0; k < 6; k++) begin
            int g;
            wdi = ~wdi;
            watch(28, g);
            if (g >= 0 && f < 0) f = g;
        end
        check(f == -1, "R5 strobing keeps high", f, -1);
        wdi = ~wdi;
        watch(80, f);
        check(f >= 38 && f <= 54, "R5 alarm after last strobe", f, TM0 * TPER);

        // R6: short glitch does not restart
        sys_restart(0, 0, 1'b1);
        clks(20);
        wdi = ~wdi;
        clks(28);
        wdi = ~wdi; clks(2); wdi = ~wdi;
        watch(60, f);
        f = f + 30;
        check(f >= 38 && f <= 54, "R6 glitch ignored", f, TM0 * TPER);

        // R10: enable low during monitoring
        sys_restart(0, 0, 1'b1);
        clks(24);
        wd_en = 0;
        watch(150, f);
        check(f == -1, "R10 disabled no alarm", f, -1);

        // R11: enable low at startup end, then raised
        sys_restart(0, 0, 1'b0);
        f = -1;
        for (int k = 0; k < 8; k++) begin
            int g;
            wdi = ~wdi;
            watch(20, g);
            if (g >= 0 && f < 0) f = g;
        end
        check(f == -1, "R11 waits for enable", f, -1);
        wd_en = 1;
        watch(80, f);
        check(f >= 38 && f <= 52, "R11 alarm after enable", f, SETC + TM0 * TPER);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule